// File: doc/BRIEF.md
# Chained Vector Arithmetic Unit

This block is a small vector execution engine. It keeps a file of vector registers, each with room for up to 64 elements. It runs four instructions, each of which applies one operation to every element of its operands:

- a unit-stride load from memory into a register;
- element-wise addition;
- element-wise multiplication;
- a unit-stride store from a register to memory.

A vector-length register sets how many elements each instruction touches. The host presents an instruction with `start`. It holds the instruction while `stall` is high and drops it after the first clock edge on which `stall` is low. Each of the three execution engines (memory, adder, multiplier) then works through the elements at one per cycle and raises its own `done` bit for a single cycle once its last element has been written.

The engines run at the same time. A consumer that reads a register still being filled by another engine does not wait for the whole vector. A per-register scoreboard counts how many elements have been written so far, and the consumer takes element i as soon as element i exists. A load can therefore feed an add, and that add can feed a multiply, all in flight together. An instruction whose destination is still read or written by a running instruction, or whose engine is busy, is held with `stall`.

The state machines are as follows.

- Arithmetic engines use AP_IDLE, AP_RUN and AP_DRAIN. AP_IDLE goes to AP_RUN on dispatch. AP_RUN goes to AP_DRAIN once the last element has been read. AP_DRAIN goes to AP_IDLE when the last result is written.
- The memory engine uses MP_IDLE, MP_LD_ISSUE, MP_LD_TAIL and MP_ST_RUN. MP_IDLE goes to MP_LD_ISSUE on a load and to MP_ST_RUN on a store. MP_LD_ISSUE goes to MP_LD_TAIL after the last read request. MP_LD_TAIL returns to MP_IDLE after one cycle. MP_ST_RUN returns to MP_IDLE when the last element is written to memory.

Top module: `vec_chain_unit`

## Requirements
- R1: `op` = 0 (load) reads memory words `base_addr`..`base_addr`+VL-1 into register `vd`, element i taken from address `base_addr`+i. Memory returns read data one cycle after the request.
- R2: `op` = 2 (add) writes `vd`[i] = (`vs1`[i] + `vs2`[i]) modulo 2^DW for i < VL.
- R3: `op` = 3 (multiply) writes `vd`[i] = the low DW bits of `vs1`[i] * `vs2`[i] for i < VL.
- R4: `op` = 1 (store) writes register `vs1`[i] to address `base_addr`+i for i < VL. `mem_we` is never high without `mem_en`.
- R5: Writing the length register clamps the value: 0 becomes 1, and anything above 64 becomes 64. The reset value is 64. Elements at index VL and above keep their previous contents.
- R6: `done` bit 0 (memory), bit 1 (add) and bit 2 (multiply) each pulse for exactly one cycle per completed instruction, the cycle after its final element is written.
- R7: A multiply that consumes a 64-element add result, dispatched one cycle after that add, finishes at most 8 cycles after the add's `done` pulse.
- R8: `stall` is high only while `start` is high. It is high when the instruction's engine is busy, or when its destination is a source or destination of a running instruction. A stalled instruction later executes with correct operands.
- R9: An add or multiply whose destination equals one of its own sources runs without deadlock and produces the element-wise result of the old contents.
- R10: `busy` is low after reset and while no engine is active. It is high while any instruction is in flight. Memory is accessed only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vl_we | input | 1 | Write strobe for the vector-length register |
| vl_wdata | input | LW+1 | New vector length, clamped to 1..VLMAX |
| start | input | 1 | Instruction valid; held while `stall` is high |
| op | input | 2 | 0 load, 1 store, 2 add, 3 multiply |
| vd | input | RW | Destination register |
| vs1 | input | RW | First source (the store source) |
| vs2 | input | RW | Second source |
| base_addr | input | AW | Scalar base address for load and store |
| stall | output | 1 | Instruction cannot be taken this cycle |
| busy | output | 1 | Some engine is active |
| done | output | 3 | Per-engine completion pulse (memory, add, multiply) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the request |

## Verification
The bench builds the unit with four registers, 64-element vectors, 16-bit elements and an 8-bit address, so a 256-word memory model covers every address the block can produce. At this size every element of every stored vector can be compared against sums and products that the bench computes itself. That includes the chained add-into-multiply pair, a multiply running in the shadow of a load, and register-reuse conflicts. Short vector lengths (1 and 5) followed by full-length stores show that the untouched tail elements keep their old values.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_MUL   = 2'd3
    } vop_e;

    localparam int NU    = 3;
    localparam int U_MEM = 0;
    localparam int U_ADD = 1;
    localparam int U_MUL = 2;
endpackage

// File: rtl/vcu_arith_pipe.sv
module vcu_arith_pipe #(
    parameter int DW     = 16,
    parameter int VLMAX  = 64,
    parameter int LAT    = 2,
    parameter bit DO_MUL = 1'b0,
    localparam int IW    = $clog2(VLMAX),
    localparam int LW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [LW-1:0] vl,
    input  logic          src_ok,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [IW-1:0] req_idx,
    output logic          busy,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          last
);
    typedef enum logic [1:0] {AP_IDLE, AP_RUN, AP_DRAIN} ap_state_e;

    ap_state_e     st, st_nx;
    logic [LW-1:0] len_q;
    logic [IW-1:0] idx_q;
    logic          issue, issue_last, wr_last;
    logic [DW-1:0] res;
    logic [LAT-1:0] pv;
    logic [IW-1:0] pi [LAT];
    logic [DW-1:0] pd [LAT];

    generate
        if (DO_MUL) begin : g_mul
            assign res = opa * opb;
        end else begin : g_add
            assign res = opa + opb;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= AP_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            AP_IDLE:  if (go)         st_nx = AP_RUN;
            AP_RUN:   if (issue_last) st_nx = AP_DRAIN;
            AP_DRAIN: if (wr_last)    st_nx = AP_IDLE;
            default:                  st_nx = AP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue      = (st == AP_RUN) && src_ok;
        issue_last = issue && (LW'(idx_q) == len_q - LW'(1));
        wr_en      = pv[LAT-1];
        wr_idx     = pi[LAT-1];
        wr_data    = pd[LAT-1];
        wr_last    = wr_en && (LW'(wr_idx) == len_q - LW'(1));
        last       = wr_last;
        busy       = (st != AP_IDLE);
        req_idx    = idx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            idx_q <= '0;
        end else if (go) begin
            len_q <= vl;
            idx_q <= '0;
        end else if (issue) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv <= '0;
        end else begin
            pv[0] <= issue;
            for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
        end
    end

    always_ff @(posedge clk) begin
        pi[0] <= idx_q;
        pd[0] <= res;
        for (int k = 1; k < LAT; k++) begin
            pi[k] <= pi[k-1];
            pd[k] <= pd[k-1];
        end
    end
endmodule

// File: rtl/vcu_mem_port.sv
module vcu_mem_port #(
    parameter int DW    = 16,
    parameter int VLMAX = 64,
    parameter int AW    = 10,
    localparam int IW   = $clog2(VLMAX),
    localparam int LW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          is_store,
    input  logic [LW-1:0] vl,
    input  logic [AW-1:0] base,
    input  logic          src_ok,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [IW-1:0] req_idx,
    output logic          busy,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          last
);
    typedef enum logic [1:0] {MP_IDLE, MP_LD_ISSUE, MP_LD_TAIL, MP_ST_RUN} mp_state_e;

    mp_state_e     st, st_nx;
    logic [LW-1:0] len_q;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] base_q;
    logic          rv_q;
    logic [IW-1:0] ridx_q;
    logic          at_end, st_fire, st_last, ld_last;

    assign at_end = (LW'(idx_q) == len_q - LW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MP_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            MP_IDLE:     if (go) st_nx = is_store ? MP_ST_RUN : MP_LD_ISSUE;
            MP_LD_ISSUE: if (at_end) st_nx = MP_LD_TAIL;
            MP_LD_TAIL:  st_nx = MP_IDLE;
            MP_ST_RUN:   if (st_last) st_nx = MP_IDLE;
            default:     st_nx = MP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        st_fire   = (st == MP_ST_RUN) && src_ok;
        st_last   = st_fire && at_end;
        mem_en    = (st == MP_LD_ISSUE) || st_fire;
        mem_we    = st_fire;
        mem_addr  = base_q + AW'(idx_q);
        mem_wdata = st_data;
        wr_en     = rv_q;
        wr_idx    = ridx_q;
        wr_data   = mem_rdata;
        ld_last   = rv_q && (LW'(ridx_q) == len_q - LW'(1));
        last      = ld_last || st_last;
        busy      = (st != MP_IDLE);
        req_idx   = idx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            idx_q  <= '0;
            base_q <= '0;
            rv_q   <= 1'b0;
            ridx_q <= '0;
        end else begin
            rv_q   <= (st == MP_LD_ISSUE);
            ridx_q <= idx_q;
            if (go) begin
                len_q  <= vl;
                idx_q  <= '0;
                base_q <= base;
            end else if ((st == MP_LD_ISSUE) || st_fire) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vec_chain_unit.sv
module vec_chain_unit
    import vcu_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int VLMAX   = 64,
    parameter int DW      = 16,
    parameter int AW      = 10,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3,
    localparam int RW     = $clog2(NREG),
    localparam int IW     = $clog2(VLMAX),
    localparam int LW     = IW + 1,
    localparam int VWD    = LW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vl_we,
    input  logic [VWD-1:0] vl_wdata,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [RW-1:0]  vd,
    input  logic [RW-1:0]  vs1,
    input  logic [RW-1:0]  vs2,
    input  logic [AW-1:0]  base_addr,
    output logic           stall,
    output logic           busy,
    output logic [2:0]     done,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata
);
    vop_e op_e;
    assign op_e = vop_e'(op);

    logic [DW-1:0] rf [NREG][VLMAX];
    logic [LW-1:0] vl_q;

    // per-register scoreboard
    logic [NREG-1:0] pend;
    logic [LW-1:0]   cnt   [NREG];
    logic [1:0]      owner [NREG];

    // per-engine tags and handshakes
    logic [RW-1:0] t_vd [NU];
    logic [RW-1:0] t_s1 [NU];
    logic [RW-1:0] t_s2 [NU];
    logic [NU-1:0] t_w, t_r1, t_r2;
    logic [NU-1:0] u_busy, u_go, u_src_ok, u_wr_en, u_last;
    logic [NU-1:0] r1_ok, r2_ok;
    logic [IW-1:0] u_req_idx [NU];
    logic [IW-1:0] u_wr_idx  [NU];
    logic [DW-1:0] u_wr_data [NU];
    logic [DW-1:0] opa       [NU];
    logic [2:0]    done_q;

    logic          new_w, new_r1, new_r2, clash, accept;
    int            sel;

    // dispatch decision
    always_comb begin
        sel    = U_MEM;
        new_w  = 1'b0;
        new_r1 = 1'b0;
        new_r2 = 1'b0;
        unique case (op_e)
            OP_LOAD:  begin sel = U_MEM; new_w = 1'b1; end
            OP_STORE: begin sel = U_MEM; new_r1 = 1'b1; end
            OP_ADD:   begin sel = U_ADD; new_w = 1'b1; new_r1 = 1'b1; new_r2 = 1'b1; end
            OP_MUL:   begin sel = U_MUL; new_w = 1'b1; new_r1 = 1'b1; new_r2 = 1'b1; end
            default:  sel = U_MEM;
        endcase
        clash = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (u_busy[u] && new_w &&
                ((t_w[u]  && (t_vd[u] == vd)) ||
                 (t_r1[u] && (t_s1[u] == vd)) ||
                 (t_r2[u] && (t_s2[u] == vd))))
                clash = 1'b1;
        end
        stall  = start && (u_busy[sel] || clash);
        accept = start && !stall;
        u_go   = accept ? (NU'(1) << sel) : '0;
    end

    // element readiness for chained consumers
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            r1_ok[u] = !t_r1[u] || !pend[t_s1[u]] ||
                       (LW'(u_req_idx[u]) < cnt[t_s1[u]]) || (owner[t_s1[u]] == 2'(u));
            r2_ok[u] = !t_r2[u] || !pend[t_s2[u]] ||
                       (LW'(u_req_idx[u]) < cnt[t_s2[u]]) || (owner[t_s2[u]] == 2'(u));
            u_src_ok[u] = r1_ok[u] && r2_ok[u];
            opa[u]      = rf[t_s1[u]][u_req_idx[u]];
        end
    end

    // memory engine
    vcu_mem_port #(.DW(DW), .VLMAX(VLMAX), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .go(u_go[U_MEM]), .is_store(op_e == OP_STORE),
        .vl(vl_q), .base(base_addr), .src_ok(u_src_ok[U_MEM]), .st_data(opa[U_MEM]),
        .mem_rdata(mem_rdata), .req_idx(u_req_idx[U_MEM]), .busy(u_busy[U_MEM]),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_en(u_wr_en[U_MEM]), .wr_idx(u_wr_idx[U_MEM]), .wr_data(u_wr_data[U_MEM]),
        .last(u_last[U_MEM])
    );

    // arithmetic engines
    generate
        for (genvar g = U_ADD; g <= U_MUL; g++) begin : g_alu
            logic [DW-1:0] opb_g;
            assign opb_g = rf[t_s2[g]][u_req_idx[g]];
            vcu_arith_pipe #(
                .DW(DW), .VLMAX(VLMAX),
                .LAT((g == U_ADD) ? ADD_LAT : MUL_LAT),
                .DO_MUL(g == U_MUL)
            ) u_alu (
                .clk(clk), .rst_n(rst_n), .go(u_go[g]), .vl(vl_q),
                .src_ok(u_src_ok[g]), .opa(opa[g]), .opb(opb_g),
                .req_idx(u_req_idx[g]), .busy(u_busy[g]),
                .wr_en(u_wr_en[g]), .wr_idx(u_wr_idx[g]), .wr_data(u_wr_data[g]),
                .last(u_last[g])
            );
        end
    endgenerate

    // register file write ports (destinations are distinct by dispatch rule)
    always_ff @(posedge clk) begin
        for (int u = 0; u < NU; u++)
            if (u_wr_en[u]) rf[t_vd[u]][u_wr_idx[u]] <= u_wr_data[u];
    end

    // length register, tags, scoreboard, done pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= LW'(VLMAX);
            pend   <= '0;
            t_w    <= '0;
            t_r1   <= '0;
            t_r2   <= '0;
            done_q <= '0;
            for (int r = 0; r < NREG; r++) begin
                cnt[r]   <= '0;
                owner[r] <= '0;
            end
            for (int u = 0; u < NU; u++) begin
                t_vd[u] <= '0;
                t_s1[u] <= '0;
                t_s2[u] <= '0;
            end
        end else begin
            if (vl_we) begin
                if (vl_wdata == '0)                 vl_q <= LW'(1);
                else if (vl_wdata > VWD'(VLMAX))    vl_q <= LW'(VLMAX);
                else                                vl_q <= vl_wdata[LW-1:0];
            end
            for (int u = 0; u < NU; u++) begin
                if (u_go[u]) begin
                    t_vd[u] <= vd;
                    t_s1[u] <= vs1;
                    t_s2[u] <= vs2;
                    t_w[u]  <= new_w;
                    t_r1[u] <= new_r1;
                    t_r2[u] <= new_r2;
                end
                if (u_wr_en[u]) begin
                    cnt[t_vd[u]] <= cnt[t_vd[u]] + 1'b1;
                    if (u_last[u]) pend[t_vd[u]] <= 1'b0;
                end
            end
            if (accept && new_w) begin
                pend[vd]  <= 1'b1;
                cnt[vd]   <= '0;
                owner[vd] <= 2'(sel);
            end
            done_q <= u_last;
        end
    end

    assign done = done_q;
    assign busy = |u_busy;
endmodule

// File: rtl/vcu_chk.sv
module vcu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       stall,
    input logic       busy,
    input logic [2:0] done,
    input logic       mem_en,
    input logic       mem_we
);
    // R8
    stall_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> start);

    // R4
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R10
    mem_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R6
    mem_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |=> !done[0]);

    // R6
    add_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] |=> !done[1]);

    // R6
    mul_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[2] |=> !done[2]);

    // R10
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done != 3'b000) |-> $past(busy));
endmodule

bind vec_chain_unit vcu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall), .busy(busy),
    .done(done), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/tb_vec_chain_unit.sv
module tb_vec_chain_unit;
    localparam int NREG = 4, VLMAX = 64, DW = 16, AW = 8;
    localparam int LW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          vl_we = 1'b0;
    logic [LW:0]   vl_wdata = '0;
    logic          start = 1'b0;
    logic [1:0]    op = '0, vd = '0, vs1 = '0, vs2 = '0;
    logic [AW-1:0] base = '0;
    logic          stall, busy, mem_en, mem_we;
    logic [2:0]    done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [256];

    vec_chain_unit #(.NREG(NREG), .VLMAX(VLMAX), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_wdata(vl_wdata),
        .start(start), .op(op), .vd(vd), .vs1(vs1), .vs2(vs2), .base_addr(base),
        .stall(stall), .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int checks = 0, fails = 0, cyc = 0;
    int dcnt [3];
    int dcyc [3];
    logic [2:0] prev_done = 3'b000;
    int n_mem = 0, n_add = 0, n_mul = 0;
    int exp_v [64];

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R6: each done bit must be a single-cycle pulse
    always @(negedge clk) begin
        for (int b = 0; b < 3; b++) begin
            if (done[b] === 1'b1) begin
                dcnt[b]++;
                dcyc[b] = cyc;
                check(prev_done[b] !== 1'b1, "R6 done pulse width", 2, 1);
            end
        end
        prev_done = done;
    end

    function automatic int va(input int i); return 3*i + 1; endfunction
    function automatic int vb(input int i); return 1000 - 7*i; endfunction

    task automatic issue(input int o, input int d, input int s1, input int s2,
                         input int a, output bit stalled);
        stalled = 1'b0;
        @(negedge clk);
        start = 1'b1; op = 2'(o); vd = 2'(d); vs1 = 2'(s1); vs2 = 2'(s2); base = AW'(a);
        #1;
        while (stall) begin
            stalled = 1'b1;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic set_vl(input int v);
        @(negedge clk);
        vl_we = 1'b1; vl_wdata = (LW+1)'(v);
        @(negedge clk);
        vl_we = 1'b0;
    endtask

    task automatic wait_cnt(input int b, input int target);
        while (dcnt[b] < target) @(negedge clk);
    endtask

    task automatic store_cmp(input int r, input int a, input string req);
        bit s;
        issue(1, 0, r, 0, a, s);
        n_mem++;
        wait_cnt(0, n_mem);
        @(negedge clk);
        for (int i = 0; i < 64; i++)
            check(mem[a+i] == 16'(exp_v[i]), req, int'(mem[a+i]), int'(16'(exp_v[i])));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit s;
        int t;
        for (int b = 0; b < 3; b++) begin dcnt[b] = 0; dcyc[b] = 0; end
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) begin
            mem[i]      = 16'(va(i));
            mem[64 + i] = 16'(vb(i));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(busy == 1'b0, "R10 busy after reset", busy, 0);
        check(done == 3'b000, "R10 done after reset", done, 0);
        check(mem_en == 1'b0, "R10 mem idle after reset", mem_en, 0);
        check(stall == 1'b0, "R8 stall without start", stall, 0);

        set_vl(64);
        // R1: two loads back to back; the second must wait for the memory engine (R8)
        issue(0, 0, 0, 0, 0, s); n_mem++;
        #1;
        check(busy == 1'b1, "R10 busy while loading", busy, 1);
        issue(0, 1, 0, 0, 64, s); n_mem++;
        check(s == 1'b1, "R8 stall on busy memory engine", s, 1);
        wait_cnt(0, n_mem);
        for (int i = 0; i < 64; i++) exp_v[i] = va(i);
        store_cmp(0, 128, "R1 R4 load/store A");
        for (int i = 0; i < 64; i++) exp_v[i] = vb(i);
        store_cmp(1, 128, "R1 R4 load/store B");

        // R7: add chained into multiply
        issue(2, 2, 0, 1, 0, s); n_add++;
        issue(3, 3, 2, 1, 0, s); n_mul++;
        check(s == 1'b0, "R7 chained multiply not stalled", s, 0);
        wait_cnt(1, n_add);
        wait_cnt(2, n_mul);
        t = dcyc[2] - dcyc[1];
        check(t > 0 && t <= 8, "R7 chain lag", t, 4);
        for (int i = 0; i < 64; i++) exp_v[i] = va(i) + vb(i);
        store_cmp(2, 128, "R2 add result");
        for (int i = 0; i < 64; i++) exp_v[i] = (va(i) + vb(i)) * vb(i);
        store_cmp(3, 128, "R3 multiply result");

        // R8: write-after-read conflict on v0
        issue(3, 2, 0, 0, 0, s); n_mul++;
        issue(2, 0, 1, 1, 0, s); n_add++;
        check(s == 1'b1, "R8 stall on destination in use", s, 1);
        wait_cnt(2, n_mul);
        wait_cnt(1, n_add);
        for (int i = 0; i < 64; i++) exp_v[i] = va(i) * va(i);
        store_cmp(2, 128, "R8 reader saw old operand");
        for (int i = 0; i < 64; i++) exp_v[i] = 2 * vb(i);
        store_cmp(0, 128, "R8 stalled writer result");

        // R5: short lengths and clamping
        set_vl(5);
        issue(2, 2, 1, 1, 0, s); n_add++;
        wait_cnt(1, n_add);
        set_vl(0);
        issue(2, 3, 0, 0, 0, s); n_add++;
        wait_cnt(1, n_add);
        set_vl(200);
        for (int i = 0; i < 64; i++) exp_v[i] = (i < 5) ? 2 * vb(i) : va(i) * va(i);
        store_cmp(2, 128, "R5 length 5 tail untouched");
        for (int i = 0; i < 64; i++) exp_v[i] = (i < 1) ? 4 * vb(i) : (va(i) + vb(i)) * vb(i);
        store_cmp(3, 128, "R5 length 0 clamps to 1, 200 to 64");

        // R9: in-place operations
        issue(2, 1, 1, 0, 0, s); n_add++;
        wait_cnt(1, n_add);
        for (int i = 0; i < 64; i++) exp_v[i] = 3 * vb(i);
        store_cmp(1, 128, "R9 in-place add");
        issue(3, 0, 0, 0, 0, s); n_mul++;
        wait_cnt(2, n_mul);
        for (int i = 0; i < 64; i++) exp_v[i] = (2 * vb(i)) * (2 * vb(i));
        store_cmp(0, 128, "R9 in-place multiply");

        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy clears when idle", busy, 0);
        check(dcnt[0] == n_mem, "R6 memory done count", dcnt[0], n_mem);
        check(dcnt[1] == n_add, "R6 add done count", dcnt[1], n_add);
        check(dcnt[2] == n_mul, "R6 multiply done count", dcnt[2], n_mul);
        finish_run();
    end
endmodule